// File: doc/BRIEF.md
# Handshaked delay-line register port

This block gives software a single 32-bit word for reaching a small byte-wide configuration register file. The file holds the delay-line settings of a storage-card interface. Software puts an address and a data byte into the word with both request bits clear. It then writes the word again with a write request or a read request set. The block carries the access over a narrow internal bus and raises an acknowledge bit when the access is done. For a read, it returns the byte in the same word.

The handshake is four-phase. Once the acknowledge bit is high it stays high for as long as either request bit is set. It drops one clock after software clears both request bits, and only then can a new access begin. The time from request to acknowledge is set by a latency input of 1 to 15 clocks, so that the driver's polling loop sees a real wait. A behavioural model of the register file sits inside the block. It implements nine input-delay entries at addresses 0x00 to 0x08 and three clock/strobe delay entries at 0x0B, 0x0C and 0x0D. Every other address is unimplemented.

Top module: `phy_reg_port`

## Requirements
- R1: After reset the port word reads 0x00000000, the internal bus request is low, and every register file byte is 0x00.
- R2: A host write loads the address from bits 5:0, the write byte from bits 15:8, the write request from bit 24 and the read request from bit 25. Bits 31:27, 26, 23:16 and 7:6 of the host data are ignored, and they read back as the block's own values (0, acknowledge, read byte and 0 respectively).
- R3: The acknowledge bit (bit 26) rises exactly L+1 clock edges after the edge that stores a request into an idle port, where L is the latency input; a latency of 0 acts as 1.
- R4: While the acknowledge bit is high it stays high as long as bit 24 or bit 25 is set, and it falls on the first edge after both are seen clear.
- R5: A write access stores the write byte at the address. A read access puts the addressed byte in bits 23:16 on the same edge that the acknowledge bit rises, and bits 23:16 change at no other time.
- R6: If bits 24 and 25 are both set, only the write is performed and bits 23:16 keep their previous value.
- R7: A request written while the acknowledge bit is high starts no access: the bus request stays low and the register file is unchanged.
- R8: At an address outside 0x00–0x08 and 0x0B–0x0D, a write changes nothing and a read returns 0x00. Both are still acknowledged.
- R9: The internal bus request is high from the edge after the request is stored until the acknowledge edge. It is never high together with the acknowledge bit. While it is high, the bus shows the access direction, the address and the write byte.
- R10: Address, data and request direction are captured when the access starts. Host writes during a pending access do not change the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat | input | 4 | Request-to-acknowledge latency in clocks (0 acts as 1) |
| host_we | input | 1 | Host write strobe for the port word |
| host_wdata | input | 32 | Host write data |
| host_word | output | 32 | Current port word as read by the host |
| phy_req | output | 1 | Internal bus request, high while an access is pending |
| phy_we | output | 1 | Internal bus direction, 1 for write |
| phy_addr | output | 6 | Internal bus address |
| phy_wdata | output | 8 | Internal bus write byte |

## Verification
A table of accesses mixes writes and reads across both implemented address ranges, one unimplemented address and one never-written entry. Latencies run from 0 to 15. The exact count of polling cycles separates a correct latency from an off-by-one or an ignored latency input, and reading each written address back separates the two address ranges. Directed sequences then set both request bits at once, re-request while the acknowledge bit is still high, and rewrite the address during a pending access. Each one ends with a read-back, which shows whether the wrong operation, a second access or a late-captured address reached the register file.

// File: rtl/phy_reg_port.sv
module phy_reg_port #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lat,
  input  logic          host_we,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_word,
  output logic          phy_req,
  output logic          phy_we,
  output logic [AW-1:0] phy_addr,
  output logic [DW-1:0] phy_wdata
);
  localparam int ACK_BIT   = 26;
  localparam int RD_BIT    = 25;
  localparam int WR_BIT    = 24;
  localparam int RDATA_LSB = 16;
  localparam int WDATA_LSB = 8;
  localparam int DEPTH     = 1 << AW;
  localparam int DLY_LAST  = 8;
  localparam int DLL_FIRST = 11;
  localparam int DLL_LAST  = 13;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_t;

  state_t        state;
  logic [AW-1:0] addr_q, op_addr;
  logic [DW-1:0] wdat_q, rdat_q, op_wdata;
  logic          wr_q, rd_q, ack_q, op_we;
  logic [LW-1:0] cnt;
  logic [DW-1:0] mem [DEPTH];
  logic          hit, fire;
  logic          unused_bits;

  assign unused_bits = ^{host_wdata[31:ACK_BIT], host_wdata[RDATA_LSB+DW-1:RDATA_LSB],
                         host_wdata[WDATA_LSB-1:AW]};

  assign hit  = (int'(op_addr) <= DLY_LAST) ||
                (int'(op_addr) >= DLL_FIRST && int'(op_addr) <= DLL_LAST);
  assign fire = (state == S_BUSY) && (cnt == LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
    end else if (host_we) begin
      addr_q <= host_wdata[AW-1:0];
      wdat_q <= host_wdata[WDATA_LSB +: DW];
      wr_q   <= host_wdata[WR_BIT];
      rd_q   <= host_wdata[RD_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ack_q    <= 1'b0;
      rdat_q   <= '0;
      op_we    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (wr_q || rd_q) begin
          state    <= S_BUSY;
          op_we    <= wr_q;
          op_addr  <= addr_q;
          op_wdata <= wdat_q;
          cnt      <= (lat == '0) ? LW'(1) : lat;
        end
        S_BUSY: if (fire) begin
          if (!op_we) rdat_q <= hit ? mem[op_addr] : '0;
          ack_q <= 1'b1;
          state <= S_DONE;
        end else begin
          cnt <= cnt - LW'(1);
        end
        default: if (!(wr_q || rd_q)) begin
          ack_q <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (fire && op_we && hit) begin
      mem[op_addr] <= op_wdata;
    end
  end

  assign phy_req   = (state == S_BUSY);
  assign phy_we    = op_we;
  assign phy_addr  = op_addr;
  assign phy_wdata = op_wdata;

  always_comb begin
    host_word = '0;
    host_word[ACK_BIT]                = ack_q;
    host_word[RD_BIT]                 = rd_q;
    host_word[WR_BIT]                 = wr_q;
    host_word[RDATA_LSB +: DW]        = rdat_q;
    host_word[WDATA_LSB +: DW]        = wdat_q;
    host_word[AW-1:0]                 = addr_q;
  end
endmodule

module phy_reg_port_chk #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          req_any,
  input logic [DW-1:0] rdata,
  input logic          phy_req,
  input logic [AW-1:0] phy_addr
);
  AST_ACK_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(phy_req)); // R3
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_any) |=> ack); // R4
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req_any) |=> !ack); // R4
  AST_RDATA_ONLY_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ack) |-> $stable(rdata)); // R5
  AST_NO_REQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !phy_req); // R7
  AST_BUS_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_req && ack)); // R9
  AST_ADDR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && $past(phy_req)) |-> $stable(phy_addr)); // R10
endmodule

bind phy_reg_port phy_reg_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack_q), .req_any(wr_q | rd_q),
  .rdata(rdat_q), .phy_req(phy_req), .phy_addr(phy_addr)
);

// File: tb/phy_reg_port_tb.sv
`timescale 1ns/1ps
module phy_reg_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  lat;
  logic        host_we;
  logic [31:0] host_wdata;
  logic [31:0] host_word;
  logic        phy_req, phy_we;
  logic [5:0]  phy_addr;
  logic [7:0]  phy_wdata;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  phy_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .lat(lat), .host_we(host_we), .host_wdata(host_wdata),
    .host_word(host_word), .phy_req(phy_req), .phy_we(phy_we),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata)
  );

  // {wr, rd, addr[5:0], data[7:0], lat[3:0], expected read byte[7:0]}
  localparam int NV = 11;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'h00, 8'hA5, 4'd1,  8'h00},
    {1'b1, 1'b0, 6'h0B, 8'h3C, 4'd15, 8'h00},
    {1'b0, 1'b1, 6'h00, 8'h00, 4'd3,  8'hA5},
    {1'b0, 1'b1, 6'h0B, 8'h00, 4'd0,  8'h3C},
    {1'b1, 1'b0, 6'h08, 8'h7E, 4'd2,  8'h00},
    {1'b1, 1'b0, 6'h0D, 8'hC3, 4'd4,  8'h00},
    {1'b0, 1'b1, 6'h08, 8'h00, 4'd5,  8'h7E},
    {1'b0, 1'b1, 6'h0D, 8'h00, 4'd1,  8'hC3},
    {1'b1, 1'b0, 6'h20, 8'h55, 4'd1,  8'h00},
    {1'b0, 1'b1, 6'h20, 8'h00, 4'd2,  8'h00},
    {1'b0, 1'b1, 6'h0C, 8'h00, 4'd1,  8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic wr, input logic rd,
                                      input logic [5:0] a, input logic [7:0] d);
    return {6'b0, rd, wr, 8'h00, d, 2'b00, a};
  endfunction

  task automatic put(input logic [31:0] w);
    @(negedge clk);
    host_we = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_ack(output int cyc);
    cyc = 0;
    while (!host_word[26] && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic release_req(input string req);
    put(32'h0);
    check(req, 32'(host_word[26]), 32'd1);
    @(negedge clk);
    check(req, 32'(host_word[26]), 32'd0);
  endtask

  task automatic do_read(input logic [5:0] a, output logic [7:0] d);
    int cyc;
    lat = 4'd1;
    put(mk(1'b0, 1'b1, a, 8'h00));
    wait_ack(cyc);
    d = host_word[23:16];
    put(32'h0);
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] rb;
    logic [31:0] w;
    rst_n = 1'b0;
    lat = 4'd1;
    host_we = 1'b0;
    host_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 word", host_word, 32'h0);
    check("R1 bus", 32'(phy_req), 32'd0);
    do_read(6'h05, rb);
    check("R1 file", 32'(rb), 32'h0);

    put(32'hFCFF_FFFF);
    check("R2 layout", host_word, 32'h0000_FF3F);
    repeat (4) @(negedge clk);
    check("R2 no access", 32'(host_word[26]), 32'd0);
    put(32'h0);

    for (int i = 0; i < NV; i++) begin
      logic wr, rd;
      logic [5:0] a;
      logic [7:0] d, e;
      logic [3:0] l;
      int lexp;
      {wr, rd, a, d, l, e} = VEC[i];
      lexp = (l == 4'd0) ? 1 : int'(l);
      lat = l;
      put(mk(wr, rd, a, d));
      check("R3 no early ack", 32'(host_word[26]), 32'd0);
      @(negedge clk);
      check("R9 bus req", {29'b0, phy_req, phy_we, 1'b0} | 32'(phy_addr != a),
            {29'b0, 1'b1, wr, 1'b0});
      wait_ack(cyc);
      check("R3 latency", 32'(cyc + 1), 32'(lexp + 1));
      check("R9 bus idle at ack", 32'(phy_req), 32'd0);
      if (rd) check("R5 R8 read byte", 32'(host_word[23:16]), 32'(e));
      release_req("R4 four-phase");
    end

    lat = 4'd2;
    put(mk(1'b1, 1'b0, 6'h01, 8'h11));
    wait_ack(cyc);
    put(32'h0);
    do_read(6'h01, rb);
    check("R5 write stored", 32'(rb), 32'h11);
    lat = 4'd3;
    put(mk(1'b1, 1'b1, 6'h02, 8'h99));
    wait_ack(cyc);
    check("R6 read dropped", 32'(host_word[23:16]), 32'h11);
    put(32'h0);
    @(negedge clk);
    do_read(6'h02, rb);
    check("R6 write done", 32'(rb), 32'h99);

    put(mk(1'b1, 1'b0, 6'h03, 8'h44));
    wait_ack(cyc);
    put(mk(1'b1, 1'b0, 6'h03, 8'h77));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (phy_req) check("R7 bus stays idle", 32'(phy_req), 32'd0);
    end
    check("R7 ack held", 32'(host_word[26]), 32'd1);
    put(32'h0);
    @(negedge clk);
    do_read(6'h03, rb);
    check("R7 file unchanged", 32'(rb), 32'h44);

    lat = 4'd10;
    put(mk(1'b1, 1'b0, 6'h04, 8'h12));
    @(negedge clk);
    put(mk(1'b1, 1'b0, 6'h05, 8'h34));
    check("R10 bus addr", 32'(phy_addr), 32'h04);
    check("R10 bus data", 32'(phy_wdata), 32'h12);
    wait_ack(cyc);
    put(32'h0);
    @(negedge clk);
    do_read(6'h04, rb);
    check("R10 captured addr", 32'(rb), 32'h12);
    do_read(6'h05, rb);
    check("R10 later addr untouched", 32'(rb), 32'h00);

    w = host_word;
    check("R2 idle word", {w[26:24], 29'b0}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule